// File: doc/BRIEF.md
# Compressed-Audio Burst Preamble Detector

This block sits behind a digital-audio receiver's subframe deframer and inspects the 16-bit payload words it extracts in the 32-bit-per-subframe word mode. It searches for the fixed 96-bit sync sequence that introduces a compressed (non-PCM) data burst. It raises a non-PCM flag when the full sequence appears. It then captures the two burst-info words that come right after the sequence.

The flag can be retriggered. Every new sync reloads a frame-timeout window. The flag drops only after a whole window of frame strobes passes with no further sync. Downstream logic uses the flag to mute or reroute PCM processing, and reads the captured words when the capture-valid pulse fires.

Top module: `burst_sync_detect`

## Requirements
- R1: A sync is six accepted words in a row: 0x0000, 0x0000, 0x0000, 0x0000, 0xF872, 0x4E1F. After the last of these words is accepted, `nonpcm_o` is high on the next cycle.
- R2: A word that does not match the expected position abandons the partial match, so an incomplete or disordered sequence does not raise the flag. If the abandoning word is 0x0000, it counts as the first zero of a fresh match. So 0x0000 ×5, 0xF872, 0x4E1F is not a sync, but 0x0000 ×4, 0xF872, 0x0000 ×4, 0xF872, 0x4E1F is.
- R3: Once set, the flag falls on the TIMEOUT_FRAMES-th (default 4096) `frame_i` strobe after the most recent sync. It is still high after TIMEOUT_FRAMES−1 strobes.
- R4: A new sync while the flag is high reloads the full window. Frame strobes counted before that sync no longer count.
- R5: The two words accepted after a sync are Pc (first) and Pd (second). When Pd is accepted, `pc_o`/`pd_o` update on the next cycle, together with a one-cycle `info_vld_o` pulse. At all other times `pc_o`/`pd_o` hold their value.
- R6: While `word_vld_i` is low, `word_i` is ignored: it neither advances nor breaks a match, and it is not captured.
- R7: While `rst_ni` is low: the flag, match progress, the timeout count, `pc_o`, `pd_o` and `info_vld_o` are all cleared to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| word_vld_i | input | 1 | Qualifies `word_i` for one cycle |
| word_i | input | 16 | Payload word from a subframe |
| frame_i | input | 1 | One-cycle strobe per received frame |
| nonpcm_o | output | 1 | Compressed burst present |
| pc_o | output | 16 | Captured burst-info word Pc |
| pd_o | output | 16 | Captured burst-info word Pd |
| info_vld_o | output | 1 | One-cycle pulse when Pc/Pd update |

## Verification
The hardest case to reach is the timeout edge. The flag must survive exactly TIMEOUT_FRAMES−1 frame strobes and fall on the next one. After a retrigger it must do so again, counted from the new sync. The stimulus reaches this by sending a burst, then issuing a precise count of frame strobes. A second burst is inserted partway through the window, and the bench then counts again from that point. A zero-broken false start shows that 0x0000 restarts matching at the first position.

// File: rtl/burst_pkg.sv
package burst_pkg;
  localparam int WORD_W  = 16;
  localparam int SYNC_N  = 6;
  localparam int IDX_W   = $clog2(SYNC_N);

  function automatic logic [WORD_W-1:0] sync_word(input logic [IDX_W-1:0] i);
    case (i)
      3'd4:    return 16'hF872;
      3'd5:    return 16'h4E1F;
      default: return '0;
    endcase
  endfunction
endpackage

// File: rtl/sync_matcher.sv
module sync_matcher
  import burst_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              word_vld_i,
  input  logic [WORD_W-1:0] word_i,
  output logic              hit_o
);
  logic [IDX_W-1:0] idx_q;
  logic             match;

  assign match = (word_i == sync_word(idx_q));
  assign hit_o = word_vld_i && match && (idx_q == IDX_W'(SYNC_N-1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q <= '0;
    end else if (word_vld_i) begin
      if (hit_o)      idx_q <= '0;
      else if (match) idx_q <= idx_q + 1'b1;
      else if (word_i == '0) idx_q <= IDX_W'(1);  // zero restarts as first word
      else            idx_q <= '0;
    end
  end

  AST_IDLE_HOLDS_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !word_vld_i |=> $stable(idx_q)); // R6
  AST_IDX_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idx_q < IDX_W'(SYNC_N)); // R2
endmodule

// File: rtl/info_capture.sv
module info_capture
  import burst_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              hit_i,
  input  logic              word_vld_i,
  input  logic [WORD_W-1:0] word_i,
  output logic [WORD_W-1:0] pc_o,
  output logic [WORD_W-1:0] pd_o,
  output logic              vld_o
);
  typedef enum logic [1:0] {CAP_IDLE, CAP_PC, CAP_PD} cap_e;
  cap_e              st_q;
  logic [WORD_W-1:0] pc_tmp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= CAP_IDLE;
      pc_tmp_q <= '0;
      pc_o     <= '0;
      pd_o     <= '0;
      vld_o    <= 1'b0;
    end else begin
      vld_o <= 1'b0;
      if (hit_i) begin
        st_q <= CAP_PC;
      end else if (word_vld_i) begin
        case (st_q)
          CAP_PC: begin
            pc_tmp_q <= word_i;
            st_q     <= CAP_PD;
          end
          CAP_PD: begin
            pc_o  <= pc_tmp_q;
            pd_o  <= word_i;
            vld_o <= 1'b1;
            st_q  <= CAP_IDLE;
          end
          default: st_q <= CAP_IDLE;
        endcase
      end
    end
  end

  AST_VLD_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_o |=> !vld_o); // R5
  AST_INFO_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vld_o |-> ($stable(pc_o) && $stable(pd_o))); // R5
endmodule

// File: rtl/hold_timer.sv
module hold_timer #(
  parameter int TIMEOUT_FRAMES = 4096,
  localparam int CNT_W = $clog2(TIMEOUT_FRAMES + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hit_i,
  input  logic frame_i,
  output logic flag_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      flag_o <= 1'b0;
    end else if (hit_i) begin
      cnt_q  <= CNT_W'(TIMEOUT_FRAMES);
      flag_o <= 1'b1;
    end else if (frame_i && flag_o) begin
      cnt_q <= cnt_q - 1'b1;
      if (cnt_q == CNT_W'(1)) flag_o <= 1'b0;
    end
  end

  AST_FLAG_ON_HIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_i |=> flag_o); // R1
  AST_FALL_ON_FRAME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(flag_o) |-> $past(frame_i)); // R3
  AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(TIMEOUT_FRAMES)); // R4
endmodule

// File: rtl/burst_sync_detect.sv
module burst_sync_detect
  import burst_pkg::*;
#(
  parameter int TIMEOUT_FRAMES = 4096
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              word_vld_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic              frame_i,
  output logic              nonpcm_o,
  output logic [WORD_W-1:0] pc_o,
  output logic [WORD_W-1:0] pd_o,
  output logic              info_vld_o
);
  logic hit;

  sync_matcher u_match (
    .clk_i, .rst_ni, .word_vld_i, .word_i, .hit_o(hit)
  );

  info_capture u_cap (
    .clk_i, .rst_ni, .hit_i(hit), .word_vld_i, .word_i,
    .pc_o, .pd_o, .vld_o(info_vld_o)
  );

  hold_timer #(.TIMEOUT_FRAMES(TIMEOUT_FRAMES)) u_timer (
    .clk_i, .rst_ni, .hit_i(hit), .frame_i, .flag_o(nonpcm_o)
  );
endmodule

// File: tb/sim_burst_sync_detect.sv
module sim_burst_sync_detect;
  localparam int TO = 4096;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        word_vld_i = 1'b0;
  logic [15:0] word_i = '0;
  logic        frame_i = 1'b0;
  logic        nonpcm_o, info_vld_o;
  logic [15:0] pc_o, pd_o;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic [31:0] exp_q[$];

  always #5 clk_i = ~clk_i;

  burst_sync_detect #(.TIMEOUT_FRAMES(TO)) u0 (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic word(input logic [15:0] w);
    @(negedge clk_i); word_vld_i = 1'b1; word_i = w; frame_i = 1'b0;
  endtask

  task automatic idle();
    @(negedge clk_i); word_vld_i = 1'b0; word_i = 16'hDEAD; frame_i = 1'b0;
  endtask

  task automatic frames(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk_i); word_vld_i = 1'b0; frame_i = 1'b1;
    end
  endtask

  task automatic sync_seq();
    for (int i = 0; i < 4; i++) word(16'h0000);
    word(16'hF872); word(16'h4E1F);
  endtask

  task automatic burst(input logic [15:0] pc, input logic [15:0] pd);
    sync_seq();
    word(pc); word(pd);
    exp_q.push_back({pc, pd});
  endtask

  // scoreboard monitor
  always @(negedge clk_i) begin
    if (rst_ni && info_vld_o) begin
      if (exp_q.size() == 0) check("R5 unexpected info_vld", 32'h1, 32'h0);
      else check("R5 pc/pd", {pc_o, pd_o}, exp_q.pop_front());
    end
  end

  initial begin
    #1;
    check("R7 reset flag", {31'b0, nonpcm_o}, 0);
    check("R7 reset pc/pd", {pc_o, pd_o}, 0);
    check("R7 reset vld", {31'b0, info_vld_o}, 0);
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    idle();
    check("R3 frames while low", {31'b0, nonpcm_o}, 0);
    frames(3); idle();
    check("R3 no flag without sync", {31'b0, nonpcm_o}, 0);

    // R1 basic burst
    burst(16'h0011, 16'h2233);
    idle(); idle();
    check("R1 flag after sync", {31'b0, nonpcm_o}, 1);
    check("R5 captured after burst", {pc_o, pd_o}, 32'h00112233);

    // R3 exact expiry
    frames(TO - 1); idle();
    check("R3 still high at TO-1", {31'b0, nonpcm_o}, 1);
    frames(1); idle();
    check("R3 low at TO", {31'b0, nonpcm_o}, 0);

    // R2 five zeros then tail: no sync
    for (int i = 0; i < 5; i++) word(16'h0000);
    word(16'hF872); word(16'h4E1F); word(16'h7777); word(16'h8888);
    idle(); idle();
    check("R2 five zeros no sync", {31'b0, nonpcm_o}, 0);
    check("R5 pc/pd held", {pc_o, pd_o}, 32'h00112233);

    // R2 disordered
    word(16'h0000); word(16'h0000); word(16'h4E1F); word(16'h0000);
    word(16'hF872); word(16'h4E1F); idle();
    check("R2 disordered no sync", {31'b0, nonpcm_o}, 0);

    // R2 zero-break restart
    for (int i = 0; i < 4; i++) word(16'h0000);
    word(16'hF872);
    burst(16'hAAAA, 16'h5555);
    idle();
    check("R2 zero restart detects", {31'b0, nonpcm_o}, 1);
    check("R5 zero restart capture", {pc_o, pd_o}, 32'hAAAA5555);

    // R4 retrigger
    frames(3000);
    burst(16'h1357, 16'h2468);
    idle();
    frames(TO - 1); idle();
    check("R4 high after retrigger TO-1", {31'b0, nonpcm_o}, 1);
    frames(1); idle();
    check("R4 low after retrigger TO", {31'b0, nonpcm_o}, 0);

    // R6 gaps and ignored words
    word(16'h0000); idle(); word(16'h0000);
    @(negedge clk_i); word_vld_i = 1'b0; word_i = 16'h1234;
    word(16'h0000); word(16'h0000); idle();
    word(16'hF872);
    @(negedge clk_i); word_vld_i = 1'b0; word_i = 16'h0000;
    word(16'h4E1F); idle(); idle();
    check("R6 gaps keep match", {31'b0, nonpcm_o}, 1);
    @(negedge clk_i); word_vld_i = 1'b0; word_i = 16'hFFFF;
    word(16'hCAFE); idle(); word(16'hBEEF);
    exp_q.push_back(32'hCAFEBEEF);
    idle(); idle();
    check("R6 gap-free capture", {pc_o, pd_o}, 32'hCAFEBEEF);

    // R7 reset mid-run
    burst(16'h4444, 16'h6666);
    idle(); idle();
    @(negedge clk_i); rst_ni = 1'b0;
    #1;
    check("R7 reset clears flag", {31'b0, nonpcm_o}, 0);
    check("R7 reset clears pc/pd", {pc_o, pd_o}, 0);
    @(negedge clk_i); rst_ni = 1'b1;
    word(16'hF872); word(16'h4E1F); idle();
    check("R7 match state cleared", {31'b0, nonpcm_o}, 0);
    idle();
    check("R5 queue drained", exp_q.size(), 0);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog act=timeout exp=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule